// File: doc/BRIEF.md
# Secured-Sector Protection Check Sequencer

This block runs, from the host side, the full check of whether a one-time secured flash sector is locked. It drives an 8-bit parallel NOR flash bus. A single `start` pulse runs the whole flow. The block drives the reset-pin level request, writes the verify command and holds off for one microsecond. It then writes the sector command, reads the status byte back, decodes it, releases the elevated reset level and writes a reset command so that the flash returns to array reads. The result is then reported with a one-cycle `done` pulse.

Each bus cycle is shaped by an internal strobe generator. It drives chip enable for a setup time, then pulses the write or read strobe, then holds chip enable. All three times are set in clock cycles by parameters. No data flows through the block as a stream, so every pin is a plain level or pulse with no handshake. Generating the high voltage itself is outside this block: `fl_hv_req` is a request bit for external circuitry.

Top module: `ssec_verify_seq`

## Requirements
- R1: Out of reset and whenever idle, `busy`, `done` and `fl_hv_req` are 0, and `fl_ce_n`, `fl_we_n` and `fl_oe_n` are all 1.
- R2: From the cycle after an accepted `start` until the status read has completed, `fl_hv_req` equals the `cfg_elevated` value sampled with `start`. The bit is 1 only while `busy` is 1.
- R3: The first bus cycle is a write of 60h to the command address `CMD_ADDR`. This address has bit 6 = 0, bit 1 = 1 and bit 0 = 0.
- R4: After the 60h write, at least `CYC_PER_US` clock cycles pass before the next write strobe ends. The gap is measured from rising `fl_we_n` to rising `fl_we_n`.
- R5: The second bus cycle is a write of 40h to the sector address. This address is `sec_addr` with bit 6 forced to 0, bit 1 forced to 1 and bit 0 forced to 0.
- R6: The third bus cycle is a read from the same forced sector address. A byte of 00h reports `res_unprotected` = 1 and a byte of 01h reports `res_protected` = 1.
- R7: Any other status byte reports `res_error` = 1, and the remaining cleanup writes still take place.
- R8: The fourth and last bus cycle is a write of F0h to `CMD_ADDR`, made with `fl_hv_req` = 0.
- R9: `done` is high for exactly one cycle after the F0h write. In that cycle exactly one of `res_protected`, `res_unprotected` and `res_error` is 1.
- R10: A `start` pulse seen while `busy` = 1 is ignored. The flow in progress keeps its address and produces no extra bus cycles.
- R11: A write strobe (`fl_we_n` = 0) and a read strobe (`fl_oe_n` = 0) are never active together. Either strobe is low only while `fl_ce_n` = 0. `fl_dq_oe` is 0 during reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins a check when idle |
| cfg_elevated | input | 1 | 1 selects the elevated reset-pin level, 0 the normal high level |
| sec_addr | input | ADDR_W | Secured-sector address; bits 6, 1, 0 are overridden |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle completion pulse |
| res_protected | output | 1 | Status byte was 01h |
| res_unprotected | output | 1 | Status byte was 00h |
| res_error | output | 1 | Status byte was any other value |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_out | output | 8 | Write data to flash |
| fl_dq_oe | output | 1 | Drive enable for write data |
| fl_dq_in | input | 8 | Read data from flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Read strobe, active low |
| fl_hv_req | output | 1 | Request for elevated reset-pin level |

## Verification
The bench builds the block with `CYC_PER_US` = 20 and setup, pulse and hold times of 1, 2 and 1 cycles. This keeps the microsecond wait short enough to run many complete checks, with both reset-level choices and a range of status bytes, while the gap measurement still tells a full wait apart from a truncated one. The bench's flash model drives a wrong byte outside the read strobe. A read sampled at the wrong phase of the strobe therefore shows up as a decode mismatch. A second `start` fired mid-flow with a different address exercises the busy-ignore rule.

// File: rtl/ssec_pkg.sv
package ssec_pkg;

  localparam logic [7:0] CMD_VERIFY  = 8'h60;
  localparam logic [7:0] CMD_SECTOR  = 8'h40;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [7:0] STAT_UNPROT = 8'h00;
  localparam logic [7:0] STAT_PROT   = 8'h01;

  typedef enum logic [1:0] {
    PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD
  } ssec_phase_t;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_ARM, SQ_W60, SQ_DLY, SQ_W40, SQ_RD, SQ_DROP, SQ_WRST, SQ_FIN
  } ssec_state_t;

  typedef struct packed {
    logic prot;
    logic unprot;
    logic err;
  } ssec_result_t;

endpackage

// File: rtl/ssec_strobe_gen.sv
module ssec_strobe_gen
  import ssec_pkg::*;
#(
  parameter int ADDR_W    = 23,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 4,
  parameter int HOLD_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              is_read,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [7:0]        dq_in,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [7:0]        rdata,
  output logic              op_done
);

  localparam int MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAXC  = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CW    = $clog2(MAXC + 1);

  ssec_phase_t   ph;
  logic [CW-1:0] cnt;
  logic          rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      rd_q   <= 1'b0;
      addr_o <= '0;
      dq_out <= '0;
      rdata  <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (go) begin
          rd_q   <= is_read;
          addr_o <= addr_i;
          dq_out <= wdata_i;
          ph     <= PH_SETUP;
          cnt    <= CW'(SETUP_CYC - 1);
        end
        PH_SETUP: if (cnt == '0) begin
          ph  <= PH_PULSE;
          cnt <= CW'(PULSE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        PH_PULSE: if (cnt == '0) begin
          if (rd_q) rdata <= dq_in;
          ph  <= PH_HOLD;
          cnt <= CW'(HOLD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) ph <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign ce_n    = (ph == PH_IDLE);
  assign we_n    = !((ph == PH_PULSE) && !rd_q);
  assign oe_n    = !((ph == PH_PULSE) && rd_q);
  assign dq_oe   = (ph != PH_IDLE) && !rd_q;
  assign op_done = (ph == PH_HOLD) && (cnt == '0);

endmodule

// File: rtl/ssec_wait_timer.sv
module ssec_wait_timer #(
  parameter int CYC_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);

  localparam int TW = $clog2(CYC_PER_US + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= TW'(CYC_PER_US);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == TW'(1));

endmodule

// File: rtl/ssec_status_decode.sv
module ssec_status_decode
  import ssec_pkg::*;
(
  input  logic [7:0]   status,
  output ssec_result_t result
);

  always_comb begin
    result = '0;
    if (status == STAT_PROT)        result.prot   = 1'b1;
    else if (status == STAT_UNPROT) result.unprot = 1'b1;
    else                            result.err    = 1'b1;
  end

endmodule

// File: rtl/ssec_verify_seq.sv
module ssec_verify_seq
  import ssec_pkg::*;
#(
  parameter int                ADDR_W     = 23,
  parameter int                CYC_PER_US = 100,
  parameter int                SETUP_CYC  = 2,
  parameter int                PULSE_CYC  = 4,
  parameter int                HOLD_CYC   = 2,
  parameter logic [ADDR_W-1:0] CMD_ADDR   = ADDR_W'('h2AA)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_elevated,
  input  logic [ADDR_W-1:0] sec_addr,
  output logic              busy,
  output logic              done,
  output logic              res_protected,
  output logic              res_unprotected,
  output logic              res_error,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_in,
  output logic              fl_ce_n,
  output logic              fl_we_n,
  output logic              fl_oe_n,
  output logic              fl_hv_req
);

  ssec_state_t       state;
  logic [ADDR_W-1:0] sec_q, sec_fixed, cmd_fixed, op_addr;
  logic [7:0]        op_data, rdata;
  logic              op_rd, op_go, op_done, issued, bus_state, tmr_exp, hv_q;
  ssec_result_t      dec, res_q;

  always_comb begin
    sec_fixed    = sec_addr;
    sec_fixed[6] = 1'b0;
    sec_fixed[1] = 1'b1;
    sec_fixed[0] = 1'b0;
    cmd_fixed    = CMD_ADDR;
    cmd_fixed[6] = 1'b0;
    cmd_fixed[1] = 1'b1;
    cmd_fixed[0] = 1'b0;
  end

  always_comb begin
    op_rd   = 1'b0;
    op_addr = cmd_fixed;
    op_data = CMD_RESET;
    case (state)
      SQ_W60: op_data = CMD_VERIFY;
      SQ_W40: begin op_addr = sec_q; op_data = CMD_SECTOR; end
      SQ_RD:  begin op_addr = sec_q; op_rd = 1'b1; end
      default: ;
    endcase
  end

  assign bus_state = (state == SQ_W60) || (state == SQ_W40) ||
                     (state == SQ_RD)  || (state == SQ_WRST);
  assign op_go     = bus_state && !issued;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      issued <= 1'b0;
      sec_q  <= '0;
      hv_q   <= 1'b0;
      res_q  <= '0;
    end else begin
      if (op_go)        issued <= 1'b1;
      else if (op_done) issued <= 1'b0;
      case (state)
        SQ_IDLE: if (start) begin
          sec_q <= sec_fixed;
          hv_q  <= cfg_elevated;
          res_q <= '0;
          state <= SQ_ARM;
        end
        SQ_ARM:  state <= SQ_W60;
        SQ_W60:  if (op_done) state <= SQ_DLY;
        SQ_DLY:  if (tmr_exp) state <= SQ_W40;
        SQ_W40:  if (op_done) state <= SQ_RD;
        SQ_RD:   if (op_done) begin
          res_q <= dec;
          hv_q  <= 1'b0;
          state <= SQ_DROP;
        end
        SQ_DROP: state <= SQ_WRST;
        SQ_WRST: if (op_done) state <= SQ_FIN;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  ssec_strobe_gen #(
    .ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
  ) i_strobe (
    .clk(clk), .rst_n(rst_n), .go(op_go), .is_read(op_rd),
    .addr_i(op_addr), .wdata_i(op_data), .dq_in(fl_dq_in),
    .addr_o(fl_addr), .dq_out(fl_dq_out), .dq_oe(fl_dq_oe),
    .ce_n(fl_ce_n), .we_n(fl_we_n), .oe_n(fl_oe_n),
    .rdata(rdata), .op_done(op_done)
  );

  ssec_wait_timer #(.CYC_PER_US(CYC_PER_US)) i_timer (
    .clk(clk), .rst_n(rst_n),
    .load((state == SQ_W60) && op_done),
    .expired(tmr_exp)
  );

  ssec_status_decode i_decode (.status(rdata), .result(dec));

  assign busy            = (state != SQ_IDLE);
  assign done            = (state == SQ_FIN);
  assign res_protected   = res_q.prot;
  assign res_unprotected = res_q.unprot;
  assign res_error       = res_q.err;
  assign fl_hv_req       = hv_q;

endmodule

// File: rtl/ssec_verify_chk.sv
module ssec_verify_chk #(
  parameter int ADDR_W     = 23,
  parameter int CYC_PER_US = 100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              res_protected,
  input logic              res_unprotected,
  input logic              res_error,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [7:0]        fl_dq_out,
  input logic              fl_dq_oe,
  input logic              fl_ce_n,
  input logic              fl_we_n,
  input logic              fl_oe_n,
  input logic              fl_hv_req
);

  logic        we_prev;
  logic [31:0] gap;
  logic        we_rise;

  assign we_rise = fl_we_n && !we_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_prev <= 1'b1;
      gap     <= '0;
    end else begin
      we_prev <= fl_we_n;
      if (we_rise && fl_dq_out == 8'h60) gap <= 32'd1;
      else if (gap != 32'hFFFF_FFFF)     gap <= gap + 1;
    end
  end

  p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fl_ce_n && fl_we_n && fl_oe_n && !fl_hv_req && !done));

  p_hv_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fl_hv_req |-> busy);

  p_cmd_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && fl_dq_out == 8'h60) |-> (!fl_addr[6] && fl_addr[1] && !fl_addr[0]));

  p_wait_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_rise && fl_dq_out == 8'h40) |-> (gap >= 32'(CYC_PER_US)));

  p_sector_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_ce_n && (fl_dq_out == 8'h40 || !fl_oe_n)) |->
      (!fl_addr[6] && fl_addr[1] && !fl_addr[0]));

  p_hv_off_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && fl_dq_out == 8'hF0) |-> !fl_hv_req);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({res_protected, res_unprotected, res_error}) == 1));

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> busy);

  p_we_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (fl_oe_n && !fl_ce_n && fl_dq_oe));

  p_oe_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> (fl_we_n && !fl_ce_n && !fl_dq_oe));

endmodule

bind ssec_verify_seq ssec_verify_chk #(
  .ADDR_W(ADDR_W), .CYC_PER_US(CYC_PER_US)
) i_chk (.*);

// File: tb/test_ssec_verify_seq.sv
module test_ssec_verify_seq;

  localparam int AW  = 23;
  localparam int US  = 20;
  localparam logic [AW-1:0] CMDA = AW'('h2AA);

  typedef struct {
    logic [AW-1:0] a;
    logic [7:0]    d;
    logic          hv;
  } bus_item_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cfg_elevated = 1'b0;
  logic [AW-1:0] sec_addr = '0, fl_addr;
  logic busy, done, res_protected, res_unprotected, res_error;
  logic [7:0] fl_dq_out, fl_dq_in, status_byte = 8'h00;
  logic fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n, fl_hv_req;

  int checks = 0, errors = 0, cyc = 0, t60 = 0;
  bit finished = 1'b0;
  bus_item_t wr_q[$], rd_q[$];
  logic [2:0] res_q[$];

  always #5 clk = ~clk;

  assign fl_dq_in = (!fl_ce_n && !fl_oe_n) ? status_byte : 8'hEE;

  ssec_verify_seq #(
    .ADDR_W(AW), .CYC_PER_US(US), .SETUP_CYC(1), .PULSE_CYC(2),
    .HOLD_CYC(1), .CMD_ADDR(CMDA)
  ) i_ssec_verify_seq (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] force_pat(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    r = a; r[6] = 1'b0; r[1] = 1'b1; r[0] = 1'b0;
    return r;
  endfunction

  // Scoreboard monitor
  logic we_p = 1'b1, oe_p = 1'b1, done_p = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (fl_we_n && !we_p) begin
        if (wr_q.size() == 0) check(0, "R10 extra write", fl_dq_out, 0);
        else begin
          bus_item_t e;
          e = wr_q.pop_front();
          check(fl_addr == e.a, (e.d == 8'h60) ? "R3 addr" : (e.d == 8'h40) ? "R5 addr" : "R8 addr", fl_addr, e.a);
          check(fl_dq_out == e.d, "R3/R5/R8 write data", fl_dq_out, e.d);
          check(fl_hv_req == e.hv, (e.d == 8'hF0) ? "R8 hv" : "R2 hv", fl_hv_req, e.hv);
          if (e.d == 8'h40) check(cyc - t60 >= US, "R4 wait", cyc - t60, US);
        end
        if (fl_dq_out == 8'h60) t60 = cyc;
      end
      if (fl_oe_n && !oe_p) begin
        if (rd_q.size() == 0) check(0, "R10 extra read", fl_addr, 0);
        else begin
          bus_item_t e;
          e = rd_q.pop_front();
          check(fl_addr == e.a, "R6 read addr", fl_addr, e.a);
          check(fl_hv_req == e.hv, "R2 hv at read", fl_hv_req, e.hv);
        end
      end
      if (done) begin
        logic [2:0] got;
        got = {res_protected, res_unprotected, res_error};
        if (res_q.size() == 0) check(0, "R9 unexpected done", got, 0);
        else begin
          logic [2:0] ex;
          ex = res_q.pop_front();
          check(got == ex, ex[0] ? "R7 result" : "R6 result", got, ex);
          check(wr_q.size() == 0, "R8 cleanup before done", wr_q.size(), 0);
        end
      end
      if (done_p) check(!done, "R9 done width", done, 0);
    end
    we_p = fl_we_n; oe_p = fl_oe_n; done_p = done;
  end

  task automatic run(input bit cfg, input logic [AW-1:0] sec, input logic [7:0] stat, input bit extra);
    bus_item_t w;
    logic [AW-1:0] sf;
    sf = force_pat(sec);
    status_byte = stat;
    w.a = CMDA; w.d = 8'h60; w.hv = cfg; wr_q.push_back(w);
    w.a = sf;   w.d = 8'h40; w.hv = cfg; wr_q.push_back(w);
    w.a = CMDA; w.d = 8'hF0; w.hv = 1'b0; wr_q.push_back(w);
    w.a = sf;   w.d = 8'h00; w.hv = cfg; rd_q.push_back(w);
    res_q.push_back(stat == 8'h01 ? 3'b100 : stat == 8'h00 ? 3'b010 : 3'b001);
    @(posedge clk); #1;
    start = 1'b1; cfg_elevated = cfg; sec_addr = sec;
    @(posedge clk); #1;
    start = 1'b0;
    if (extra) begin
      repeat (8) @(posedge clk);
      #1 start = 1'b1; sec_addr = ~sec; cfg_elevated = ~cfg;
      @(posedge clk); #1 start = 1'b0;
    end
    while (!done) @(posedge clk);
    repeat (3) @(negedge clk);
    check(!busy && fl_ce_n && !fl_hv_req, "R1 idle after run", {busy, fl_ce_n, fl_hv_req}, 3'b010);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(fl_ce_n && fl_we_n && fl_oe_n, "R1 bus idle in reset", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    check(!busy && !done && !fl_hv_req, "R1 status in reset", {busy, done, fl_hv_req}, 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!busy && fl_ce_n, "R1 idle after reset", {busy, fl_ce_n}, 2'b01);
    run(1'b1, AW'('h12345), 8'h01, 1'b0);   // R6 protected, elevated level
    run(1'b0, AW'('h7FFFFF), 8'h00, 1'b0);  // R6 unprotected, normal level
    run(1'b1, AW'('h000041), 8'h5A, 1'b0);  // R7 error
    run(1'b0, AW'('h3C3C3), 8'hFF, 1'b0);   // R7 error
    run(1'b1, AW'('h0ABCD), 8'h01, 1'b1);   // R10 start while busy
    run(1'b0, AW'('h55555), 8'h02, 1'b1);   // R10 and R7
    check(wr_q.size() == 0 && rd_q.size() == 0 && res_q.size() == 0, "R10 queues drained",
          wr_q.size() + rd_q.size() + res_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule